// File: doc/BRIEF.md
# Multiplexed Address/Data Burst Target

This block answers transactions on a synchronous 32-bit bus whose address and data share one set of lines. An initiator raises the frame line for one cycle with an address on the shared lines and a command on the four control lines. It then runs one or more data phases. In those phases the same four control lines act as per-byte valid flags. The target decodes the command and checks the address against its windows. If the transaction is its own, it raises a claim line and serves the data phases from a 64-word register array.

The target paces each data phase with its ready line and inserts a configurable number of wait cycles before every phase. A phase completes only on a cycle where both ready lines are high. The word index steps by one, which is four bytes, after every completed phase. When a burst reaches the last word of the window while the initiator still wants more, the target raises stop together with ready. That phase completes and the burst ends. Both the memory window and the I/O window select the same register array.

Top module: `mux_ad_target`

## Requirements
- R1: After synchronous active-low reset, tgt_claim, tgt_ready, tgt_stop and bus_ad_oe are low, and every register word reads as zero.
- R2: In an address phase (bus_frame high while idle), command 4'b0110 (memory read) or 4'b0111 (memory write) is claimed when address bits [31:8] equal MEM_BASE[31:8]. Command 4'b0010 (I/O read) or 4'b0011 (I/O write) is claimed when they equal IO_BASE[31:8]. Address bits [7:2] select the word. Both windows map the same array. tgt_claim is high from the cycle after the address phase.
- R3: Any other command, or an address outside the matching window, is not claimed. tgt_claim and tgt_ready stay low, and no register changes.
- R4: tgt_ready rises after exactly WAIT_CYCLES low cycles, counted from the cycle after the address phase. The same gap follows every completed data phase.
- R5: A data phase completes only on a cycle with bus_irdy and tgt_ready both high. While bus_irdy is low, tgt_ready stays high and the word index does not move.
- R6: On a completed write phase, byte lane i (bus_ad_in[8i+7:8i]) is written only when bus_cbe[i] is 1.
- R7: During read data phases, bus_ad_oe is high and bus_ad_out carries the selected word. Byte lane i is forced to zero when bus_cbe[i] is 0.
- R8: Each completed data phase that is not the last advances the word index by one (four bytes).
- R9: If a phase at word 63 is reached with bus_frame still high, tgt_stop is raised together with tgt_ready. After that phase completes, tgt_stop stays high and tgt_ready stays low until bus_frame falls. A burst whose final phase is word 63 gets no stop.
- R10: When a data phase completes with bus_frame low, the transaction ends and tgt_claim is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_frame | input | 1 | Initiator frame; high on the address phase and on every data phase but the last |
| bus_irdy | input | 1 | Initiator ready for the current data phase |
| bus_ad_in | input | 32 | Shared address/data lines as driven by the initiator |
| bus_cbe | input | 4 | Command in the address phase, byte valid flags in data phases |
| bus_ad_out | output | 32 | Read data driven by the target |
| bus_ad_oe | output | 1 | Target drives the shared lines |
| tgt_ready | output | 1 | Target ready for the current data phase |
| tgt_stop | output | 1 | Target ends the burst |
| tgt_claim | output | 1 | Target owns the current transaction |

## Verification
The embedded properties watch the handshake on every cycle. Ready is held while the initiator stalls, stop is held until frame falls, and claim drops only after a final phase. The index steps once per non-final completion. Ready never appears without a claim, and read drive appears only inside a claimed transaction. Only the directed scenarios can show the data content: byte-lane merging on writes, masked read data, and the sharing of one array between the two windows. They also show the exact wait count, the word at which stop appears, and that unclaimed cycles leave storage untouched.

// File: rtl/mux_ad_target_pkg.sv
// Shared constants and types for the multiplexed address/data target.
// Assumes a 32-bit shared bus with one control line per byte lane.
package mux_ad_target_pkg;
    localparam int AD_W  = 32;
    localparam int LANES = AD_W / 8;

    localparam logic [LANES-1:0] CMD_IO_RD  = 4'b0010;
    localparam logic [LANES-1:0] CMD_IO_WR  = 4'b0011;
    localparam logic [LANES-1:0] CMD_MEM_RD = 4'b0110;
    localparam logic [LANES-1:0] CMD_MEM_WR = 4'b0111;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_DRAIN = 2'd2,
        ST_SKIP  = 2'd3
    } tgt_state_e;
endpackage

// File: rtl/mux_ad_target_decode.sv
// Address-phase decoder: classifies the command and matches the address
// against the memory and I/O windows. Purely combinational.
// Assumes each window spans WORDS 32-bit words aligned to its own size.
module mux_ad_target_decode
    import mux_ad_target_pkg::*;
#(
    parameter logic [AD_W-1:0] MEM_BASE = 32'h8000_0000,
    parameter logic [AD_W-1:0] IO_BASE  = 32'h0000_1000,
    parameter int              IDX_W    = 6
) (
    input  logic [AD_W-1:2]  addr_w,
    input  logic [LANES-1:0] cmd,
    output logic             hit,
    output logic             is_write,
    output logic [IDX_W-1:0] idx
);
    localparam int LO = IDX_W + 2;

    logic mem_match;
    logic io_match;

    assign mem_match = (addr_w[AD_W-1:LO] == MEM_BASE[AD_W-1:LO]);
    assign io_match  = (addr_w[AD_W-1:LO] == IO_BASE[AD_W-1:LO]);
    assign idx       = addr_w[LO-1:2];

    // Command classification and window selection
    always_comb begin
        hit      = 1'b0;
        is_write = 1'b0;
        case (cmd)
            CMD_MEM_RD: hit = mem_match;
            CMD_MEM_WR: begin hit = mem_match; is_write = 1'b1; end
            CMD_IO_RD:  hit = io_match;
            CMD_IO_WR:  begin hit = io_match;  is_write = 1'b1; end
            default:    hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/mux_ad_target_regs.sv
// Register array split into byte lanes; each lane is written only when its
// enable is set, and read lanes with a clear enable return zero.
// Assumes a single write port and a single combinational read port.
module mux_ad_target_regs
    import mux_ad_target_pkg::*;
#(
    parameter int WORDS = 64,
    parameter int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [LANES-1:0] wr_be,
    input  logic [AD_W-1:0]  wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [LANES-1:0] rd_be,
    output logic [AD_W-1:0]  rd_data
);
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        logic [7:0] lane_q [WORDS];

        // Lane storage: cleared on reset, written per byte enable
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < WORDS; i++) lane_q[i] <= 8'h00;
            end else if (wr_en && wr_be[ln]) begin
                lane_q[wr_idx] <= wr_data[8*ln +: 8];
            end
        end

        assign rd_data[8*ln +: 8] = rd_be[ln] ? lane_q[rd_idx] : 8'h00;
    end
endmodule

// File: rtl/mux_ad_target_ctrl.sv
// Transaction sequencer: captures the address phase, paces data phases with
// wait cycles, steps the word index, and ends bursts at the window edge.
// Assumes the initiator drops frame on its final phase and after a stop.
module mux_ad_target_ctrl
    import mux_ad_target_pkg::*;
#(
    parameter int WORDS       = 64,
    parameter int IDX_W       = $clog2(WORDS),
    parameter int WAIT_CYCLES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame,
    input  logic             irdy,
    input  logic             dec_hit,
    input  logic             dec_write,
    input  logic [IDX_W-1:0] dec_idx,
    output logic             claim,
    output logic             trdy,
    output logic             stop,
    output logic             wr_fire,
    output logic             rd_active,
    output logic [IDX_W-1:0] cur_idx
);
    localparam int               WAIT_W = (WAIT_CYCLES > 0) ? $clog2(WAIT_CYCLES + 1) : 1;
    localparam logic [WAIT_W-1:0] WAIT_LD = WAIT_W'(WAIT_CYCLES);
    localparam logic [IDX_W-1:0]  LAST   = IDX_W'(WORDS - 1);

    tgt_state_e        state_q;
    logic [WAIT_W-1:0] wcnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic              write_q;
    logic              phase_done;
    logic              at_last;

    assign trdy       = (state_q == ST_XFER) && (wcnt_q == '0);
    assign phase_done = trdy && irdy;
    assign at_last    = (idx_q == LAST);
    assign stop       = (trdy && at_last && frame) || (state_q == ST_DRAIN);
    assign claim      = (state_q == ST_XFER) || (state_q == ST_DRAIN);
    assign wr_fire    = phase_done && write_q;
    assign rd_active  = (state_q == ST_XFER) && !write_q;
    assign cur_idx    = idx_q;

    // Transaction state, wait counter, index and direction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wcnt_q  <= '0;
            idx_q   <= '0;
            write_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (frame) begin
                        if (dec_hit) begin
                            state_q <= ST_XFER;
                            idx_q   <= dec_idx;
                            write_q <= dec_write;
                            wcnt_q  <= WAIT_LD;
                        end else begin
                            state_q <= ST_SKIP;
                        end
                    end
                end
                ST_XFER: begin
                    if (phase_done) begin
                        if (!frame) begin
                            state_q <= ST_IDLE;
                        end else if (at_last) begin
                            state_q <= ST_DRAIN;
                        end else begin
                            idx_q  <= idx_q + 1'b1;
                            wcnt_q <= WAIT_LD;
                        end
                    end else if (wcnt_q != '0) begin
                        wcnt_q <= wcnt_q - 1'b1;
                    end
                end
                ST_DRAIN: begin
                    if (!frame) state_q <= ST_IDLE;
                end
                default: begin
                    if (!frame && !irdy) state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // R5
    trdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trdy && !irdy) |=> (trdy && cur_idx == $past(cur_idx)));

    // R8
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_done && frame && !stop) |=> (cur_idx == $past(cur_idx) + 1'b1));

    // R9
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && frame) |=> stop);

    // R10
    claim_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(claim) |-> !$past(frame));

    if (WAIT_CYCLES > 0) begin : g_wait_chk
        // R4
        wait_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(trdy) |-> ($past(claim) && !$past(trdy)));
    end
endmodule

// File: rtl/mux_ad_target.sv
// Top of the multiplexed address/data burst target: ties the decoder,
// sequencer and byte-lane register array to the shared bus lines.
// Assumes the shared lines are split into separate in/out with an enable.
module mux_ad_target
    import mux_ad_target_pkg::*;
#(
    parameter logic [31:0] MEM_BASE    = 32'h8000_0000,
    parameter logic [31:0] IO_BASE     = 32'h0000_1000,
    parameter int          WORDS       = 64,
    parameter int          WAIT_CYCLES = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_frame,
    input  logic        bus_irdy,
    input  logic [31:0] bus_ad_in,
    input  logic [3:0]  bus_cbe,
    output logic [31:0] bus_ad_out,
    output logic        bus_ad_oe,
    output logic        tgt_ready,
    output logic        tgt_stop,
    output logic        tgt_claim
);
    localparam int IDX_W = $clog2(WORDS);

    logic             dec_hit;
    logic             dec_write;
    logic [IDX_W-1:0] dec_idx;
    logic             wr_fire;
    logic             rd_active;
    logic [IDX_W-1:0] cur_idx;
    logic [AD_W-1:0]  rd_data;

    mux_ad_target_decode #(
        .MEM_BASE (MEM_BASE),
        .IO_BASE  (IO_BASE),
        .IDX_W    (IDX_W)
    ) u_decode (
        .addr_w   (bus_ad_in[AD_W-1:2]),
        .cmd      (bus_cbe),
        .hit      (dec_hit),
        .is_write (dec_write),
        .idx      (dec_idx)
    );

    mux_ad_target_ctrl #(
        .WORDS       (WORDS),
        .IDX_W       (IDX_W),
        .WAIT_CYCLES (WAIT_CYCLES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame     (bus_frame),
        .irdy      (bus_irdy),
        .dec_hit   (dec_hit),
        .dec_write (dec_write),
        .dec_idx   (dec_idx),
        .claim     (tgt_claim),
        .trdy      (tgt_ready),
        .stop      (tgt_stop),
        .wr_fire   (wr_fire),
        .rd_active (rd_active),
        .cur_idx   (cur_idx)
    );

    mux_ad_target_regs #(
        .WORDS (WORDS),
        .IDX_W (IDX_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_fire),
        .wr_idx  (cur_idx),
        .wr_be   (bus_cbe),
        .wr_data (bus_ad_in),
        .rd_idx  (cur_idx),
        .rd_be   (bus_cbe),
        .rd_data (rd_data)
    );

    assign bus_ad_oe  = rd_active;
    assign bus_ad_out = rd_active ? rd_data : '0;

    // R3
    ready_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_ready |-> tgt_claim);

    // R7
    drive_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ad_oe |-> (tgt_claim && !(tgt_stop && !tgt_ready)));
endmodule

// File: tb/mux_ad_target_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module mux_ad_target_bench;
    localparam logic [31:0] MEM_BASE = 32'h8000_0000;
    localparam logic [31:0] IO_BASE  = 32'h0000_1000;
    localparam int          WAITS    = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_frame = 1'b0;
    logic        bus_irdy = 1'b0;
    logic [31:0] bus_ad_in = '0;
    logic [3:0]  bus_cbe = '0;
    logic [31:0] bus_ad_out;
    logic        bus_ad_oe;
    logic        tgt_ready;
    logic        tgt_stop;
    logic        tgt_claim;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] wdata [8];
    logic [3:0]  wbe   [8];
    logic [31:0] rdata [8];
    int          done_cnt;
    bit          saw_stop;
    logic        post_claim, post_stop, post_rdy;

    mux_ad_target #(
        .MEM_BASE (MEM_BASE), .IO_BASE (IO_BASE), .WORDS (64), .WAIT_CYCLES (WAITS)
    ) u_mux_ad_target (
        .clk (clk), .rst_n (rst_n), .bus_frame (bus_frame), .bus_irdy (bus_irdy),
        .bus_ad_in (bus_ad_in), .bus_cbe (bus_cbe), .bus_ad_out (bus_ad_out),
        .bus_ad_oe (bus_ad_oe), .tgt_ready (tgt_ready), .tgt_stop (tgt_stop),
        .tgt_claim (tgt_claim)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Initiator: address phase, then up to n data phases using wdata/wbe
    task automatic run_burst(input logic [3:0] cmd, input logic [31:0] addr,
                             input int n, input int hold);
        int  ph = 0;
        int  waits;
        int  hc;
        bit  fin = 0;
        bit  rdy_seen;
        done_cnt = 0;
        saw_stop = 0;
        @(negedge clk);
        bus_frame = 1'b1; bus_ad_in = addr; bus_cbe = cmd; bus_irdy = 1'b0;
        while (!fin) begin
            @(negedge clk);
            bus_frame = (ph < n - 1);
            bus_ad_in = cmd[0] ? wdata[ph] : 32'hA5A5_5A5A;
            bus_cbe   = wbe[ph];
            hc        = (ph == 0) ? hold : 0;
            bus_irdy  = (hc == 0);
            waits     = 0;
            rdy_seen  = 0;
            forever begin
                #1;
                if (rdy_seen && !tgt_ready) chk("R5 ready held", 0, 1);
                if (tgt_ready && bus_irdy) break;
                if (tgt_ready) rdy_seen = 1;
                else waits++;
                @(negedge clk);
                if (hc > 0) begin hc--; if (hc == 0) bus_irdy = 1'b1; end
            end
            chk("R4 wait cycles", waits, WAITS);
            chk("R2 claimed", {31'd0, tgt_claim}, 1);
            if (!cmd[0]) chk("R7 read drive", {31'd0, bus_ad_oe}, 1);
            rdata[ph] = bus_ad_out;
            ph++;
            done_cnt = ph;
            if (tgt_stop) begin saw_stop = 1; fin = 1; end
            else if (ph == n) fin = 1;
        end
        @(negedge clk);
        #1;
        post_claim = tgt_claim; post_stop = tgt_stop; post_rdy = tgt_ready;
        bus_frame = 1'b0; bus_irdy = 1'b0; bus_cbe = '0; bus_ad_in = '0;
        @(negedge clk);
    endtask

    task automatic rd1(input logic [31:0] addr, input logic [3:0] be, output logic [31:0] d);
        wbe[0] = be;
        run_burst(4'b0110, addr, 1, 0);
        d = rdata[0];
    endtask

    task automatic t_reset();
        logic [31:0] d;
        #1;
        chk("R1 claim", {31'd0, tgt_claim}, 0);
        chk("R1 ready", {31'd0, tgt_ready}, 0);
        chk("R1 stop", {31'd0, tgt_stop}, 0);
        chk("R1 oe", {31'd0, bus_ad_oe}, 0);
        rd1(MEM_BASE + 32'h40, 4'hF, d);
        chk("R1 word zero", d, 32'h0);
    endtask

    task automatic t_single();
        logic [31:0] d;
        wdata[0] = 32'h1122_3344; wbe[0] = 4'hF;
        run_burst(4'b0111, MEM_BASE + 32'h10, 1, 0);
        chk("R10 claim ends", {31'd0, post_claim}, 0);
        rd1(MEM_BASE + 32'h10, 4'hF, d);
        chk("R6 full write", d, 32'h1122_3344);
        chk("R10 read claim ends", {31'd0, post_claim}, 0);
    endtask

    task automatic t_bytes();
        logic [31:0] d;
        wdata[0] = 32'hAABB_CCDD; wbe[0] = 4'b0101;
        run_burst(4'b0111, MEM_BASE + 32'h10, 1, 0);
        rd1(MEM_BASE + 32'h10, 4'hF, d);
        chk("R6 lane merge", d, 32'h11BB_33DD);
        rd1(MEM_BASE + 32'h10, 4'b0011, d);
        chk("R7 masked read", d, 32'h0000_33DD);
    endtask

    task automatic t_burst();
        for (int i = 0; i < 4; i++) begin
            wdata[i] = 32'hC0DE_0000 + 32'(i * 17); wbe[i] = 4'hF;
        end
        run_burst(4'b0011, IO_BASE + 32'h20, 4, 0);
        chk("R8 write phases", done_cnt, 4);
        for (int i = 0; i < 4; i++) wbe[i] = 4'hF;
        run_burst(4'b0110, MEM_BASE + 32'h20, 4, 3);
        for (int i = 0; i < 4; i++)
            chk("R8 burst readback", rdata[i], 32'hC0DE_0000 + 32'(i * 17));
        chk("R5 stalled burst words", done_cnt, 4);
    endtask

    task automatic t_stop();
        logic [31:0] d;
        for (int i = 0; i < 4; i++) begin
            wdata[i] = 32'h5100_0000 + 32'(i); wbe[i] = 4'hF;
        end
        run_burst(4'b0111, MEM_BASE + 32'hF8, 4, 0);
        chk("R9 stop seen", {31'd0, saw_stop}, 1);
        chk("R9 phases before stop", done_cnt, 2);
        chk("R9 drain stop", {31'd0, post_stop}, 1);
        chk("R9 drain claim", {31'd0, post_claim}, 1);
        chk("R9 drain ready", {31'd0, post_rdy}, 0);
        rd1(MEM_BASE + 32'hFC, 4'hF, d);
        chk("R9 last word", d, 32'h5100_0001);
        chk("R9 no stop on final", {31'd0, saw_stop}, 0);
        rd1(MEM_BASE + 32'h00, 4'hF, d);
        chk("R9 no wrap", d, 32'h0);
    endtask

    task automatic unclaimed(input logic [3:0] cmd, input logic [31:0] addr);
        bit bad = 0;
        @(negedge clk);
        bus_frame = 1'b1; bus_ad_in = addr; bus_cbe = cmd; bus_irdy = 1'b0;
        @(negedge clk);
        bus_frame = 1'b0; bus_irdy = 1'b1; bus_ad_in = 32'hFFFF_FFFF; bus_cbe = 4'hF;
        for (int i = 0; i < 6; i++) begin
            #1;
            if (tgt_claim || tgt_ready) bad = 1;
            @(negedge clk);
            if (i == 3) bus_irdy = 1'b0;
        end
        chk("R3 not claimed", {31'd0, bad}, 0);
        bus_cbe = '0; bus_ad_in = '0;
    endtask

    task automatic t_ignore();
        logic [31:0] d;
        unclaimed(4'b1010, MEM_BASE + 32'h10);
        unclaimed(4'b0111, MEM_BASE + 32'h110);
        unclaimed(4'b0011, MEM_BASE + 32'h10);
        rd1(MEM_BASE + 32'h10, 4'hF, d);
        chk("R3 storage untouched", d, 32'h11BB_33DD);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_bytes();
        t_burst();
        t_stop();
        t_ignore();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule